// File: doc/BRIEF.md
# Precise Exception Sequencing Controller

This block sits at the completion stage of an in-order pipeline and decides, cycle by cycle, whether an exception is taken and which one. It watches the instruction in the completion slot (its address and a vector of fault flags), a bank of external interrupt requests, a system-reset request and a machine-check request. When an exception wins, the same cycle raises a flush and a redirect to the fixed vector for that exception. At the next clock edge the return address and the old machine state are captured into two save registers, and the machine state is switched to supervisor mode with external interrupts disabled.

External interrupts are precise. A request is latched into a pending bit as soon as it arrives. It is serviced only at an instruction boundary: the completing instruction finishes without fault, the completed-store queue reports empty, interrupts are enabled in the machine state, and the source is unmasked. Instruction faults are precise. The faulting instruction is blocked from committing and its address is saved, except for the classes listed in a parameter mask (trap and system call by default), which save the address of the following instruction. An exception-return pulse copies the saved state back and redirects fetch to the saved address in one cycle.

Top module: `exc_seq_ctrl`

## Requirements
- R1: When an exception is taken, `flush` and `redirect` are high in that cycle and `redirect_pc` equals `VEC_BASE + (code+1) << VEC_SHIFT`. From the next cycle, machine-state bit 1 (user mode) and bit 0 (interrupt enable) are both 0, so `supervisor` is 1.
- R2: On entry, `srr1` receives the machine state from before the entry, and `srr0` receives the return address defined by R5, R6 and R8.
- R3: When several causes are present in one cycle, the winner is chosen by fixed priority: system reset (code 0) first, then machine check (code 1), then an instruction fault (code 2+i), then an external interrupt (code 2+NS+j).
- R4: When several fault flags of the completing instruction are set, the lowest-index flag is serviced. The others are left for later.
- R5: A fault of a valid completing instruction blocks `cmp_commit`. The saved address is `cmp_pc`, or `cmp_pc+ILEN` for fault indices set in `AFTER_MASK` (default: indices 2 and 3).
- R6: An external request sets a pending bit. The lowest-index pending bit that is unmasked is taken only when all of these hold: machine-state bit 0 is 1, `sq_empty` is 1, a valid instruction completes without fault, no return pulse is present, and no higher-priority cause is present. The instruction commits, `srr0` gets `cmp_pc+ILEN`, and the pending bit is cleared.
- R7: A pending request that is masked, or blocked because machine-state bit 0 is 0, stays pending. It is taken once it is enabled.
- R8: System reset and machine check are taken regardless of machine-state bit 0 or `sq_empty`, including inside a handler. They block the commit and save `cmp_pc`.
- R9: A return pulse with no exception in that cycle redirects to `srr0` in the same cycle and loads the machine state from `srr1` at the next edge. A return pulse is ignored when an exception is taken.
- R10: A software write loads `msr_wdata` into the machine state, unless an exception or a return occurs in the same cycle.
- R11: After reset, the machine state, both save registers and all pending bits are 0, and no exception is signalled while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Completion slot holds an instruction |
| cmp_pc | input | AW | Address of the completing instruction |
| cmp_fault | input | NS | Fault flags of the completing instruction |
| ext_req | input | NA | External interrupt request pulses |
| irq_en_mask | input | NA | Per-source interrupt enable |
| sq_empty | input | 1 | Completed-store queue is empty |
| sreset_req | input | 1 | System-reset exception request |
| mcheck_req | input | 1 | Machine-check exception request |
| rfi | input | 1 | Exception-return pulse |
| msr_wr | input | 1 | Software write of the machine state |
| msr_wdata | input | MW | Machine-state write data |
| flush | output | 1 | Flush the pipeline (exception taken) |
| cmp_commit | output | 1 | Completing instruction may commit |
| redirect | output | 1 | Fetch redirect valid |
| redirect_pc | output | AW | Redirect target |
| take | output | 1 | An exception is taken this cycle |
| take_code | output | CW | Code of the exception taken |
| srr0 | output | AW | Saved return address |
| srr1 | output | MW | Saved machine state |
| msr | output | MW | Current machine state |
| supervisor | output | 1 | Supervisor mode (machine-state bit 1 clear) |

## Verification
The checker watches every cycle for the following:
- a system-reset or machine-check request always wins with its own code;
- a faulting instruction never commits;
- an interrupt is only taken with the store queue empty, interrupts enabled and the instruction committing;
- entry saves the old state and drops to supervisor with interrupts off;
- a return restores the saved state.

Other properties need the bench's reference model over multi-cycle scenarios:
- the full priority order among simultaneous causes;
- the choice among several fault flags;
- the return-address offset for the trap classes;
- a masked or disabled request surviving until it is enabled.

// File: rtl/exc_pkg.sv
package exc_pkg;
    // Bit positions inside the machine-state word.
    localparam int unsigned MS_IE_BIT   = 0;  // external interrupts enabled
    localparam int unsigned MS_USER_BIT = 1;  // user (non-supervisor) mode
    // Fixed cause codes ahead of the parameterised groups.
    localparam int unsigned CODE_SRESET = 0;
    localparam int unsigned CODE_MCHECK = 1;
    localparam int unsigned CODE_SYNC0  = 2;
endpackage

// File: rtl/exc_pick.sv
module exc_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Lowest index wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/exc_pend.sv
module exc_pend #(
    parameter int N = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  set,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  pend
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic bit_d, bit_q;
        always_comb begin
            bit_d = bit_q;
            if (clr_en && clr_idx == IW'(g)) bit_d = 1'b0;
            if (set[g]) bit_d = 1'b1;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end
        assign pend[g] = bit_q;
    end
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl #(
    parameter int AW = 32,
    parameter int MW = 8,
    parameter int NS = 4,
    parameter int NA = 2,
    parameter logic [AW-1:0] VEC_BASE = '0,
    parameter int VEC_SHIFT = 8,
    parameter logic [NS-1:0] AFTER_MASK = 4'b1100,
    parameter int ILEN = 4,
    localparam int NCODE = 2 + NS + NA,
    localparam int CW = $clog2(NCODE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_valid,
    input  logic [AW-1:0] cmp_pc,
    input  logic [NS-1:0] cmp_fault,
    input  logic [NA-1:0] ext_req,
    input  logic [NA-1:0] irq_en_mask,
    input  logic          sq_empty,
    input  logic          sreset_req,
    input  logic          mcheck_req,
    input  logic          rfi,
    input  logic          msr_wr,
    input  logic [MW-1:0] msr_wdata,
    output logic          flush,
    output logic          cmp_commit,
    output logic          redirect,
    output logic [AW-1:0] redirect_pc,
    output logic          take,
    output logic [CW-1:0] take_code,
    output logic [AW-1:0] srr0,
    output logic [MW-1:0] srr1,
    output logic [MW-1:0] msr,
    output logic          supervisor
);
    import exc_pkg::*;

    localparam int SIW = (NS > 1) ? $clog2(NS) : 1;
    localparam int AIW = (NA > 1) ? $clog2(NA) : 1;

    typedef struct packed {
        logic [MW-1:0] ms;
        logic [AW-1:0] ret;
        logic [MW-1:0] saved;
    } state_t;

    state_t s_d, s_q;

    logic [NS-1:0]  sync_req;
    logic           sync_any;
    logic [SIW-1:0] sync_idx;
    logic [NA-1:0]  pend_q, async_req;
    logic           async_any;
    logic [AIW-1:0] async_idx;
    logic           take_sr, take_mc, take_sy, take_as, async_ok;
    logic [AW-1:0]  ret_addr, vec_addr;

    assign sync_req  = cmp_valid ? cmp_fault : '0;
    assign async_req = pend_q & irq_en_mask;

    exc_pick #(.N(NS)) u_sync_pick (
        .req (sync_req),
        .any (sync_any),
        .idx (sync_idx)
    );

    exc_pick #(.N(NA)) u_async_pick (
        .req (async_req),
        .any (async_any),
        .idx (async_idx)
    );

    exc_pend #(.N(NA)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (ext_req),
        .clr_en  (take_as),
        .clr_idx (async_idx),
        .pend    (pend_q)
    );

    // Arbitration and redirect, same cycle.
    always_comb begin
        async_ok = s_q.ms[MS_IE_BIT] && sq_empty && cmp_valid && !rfi;
        take_sr  = sreset_req;
        take_mc  = mcheck_req && !take_sr;
        take_sy  = sync_any && !take_sr && !take_mc;
        take_as  = async_any && async_ok && !take_sr && !take_mc && !sync_any;

        take_code = '0;
        ret_addr  = cmp_pc;
        if (take_sr) begin
            take_code = CW'(CODE_SRESET);
        end else if (take_mc) begin
            take_code = CW'(CODE_MCHECK);
        end else if (take_sy) begin
            take_code = CW'(CODE_SYNC0) + CW'(sync_idx);
            if (AFTER_MASK[sync_idx]) ret_addr = cmp_pc + AW'(ILEN);
        end else if (take_as) begin
            take_code = CW'(CODE_SYNC0 + NS) + CW'(async_idx);
            ret_addr  = cmp_pc + AW'(ILEN);
        end

        take        = take_sr || take_mc || take_sy || take_as;
        vec_addr    = VEC_BASE + ((AW'(take_code) + AW'(1)) << VEC_SHIFT);
        flush       = take;
        redirect    = take || rfi;
        redirect_pc = take ? vec_addr : s_q.ret;
        cmp_commit  = cmp_valid && !take_sr && !take_mc && !take_sy;
    end

    // Next state of the save registers and machine state.
    always_comb begin
        s_d = s_q;
        if (take) begin
            s_d.ret                = ret_addr;
            s_d.saved              = s_q.ms;
            s_d.ms[MS_IE_BIT]      = 1'b0;
            s_d.ms[MS_USER_BIT]    = 1'b0;
        end else if (rfi) begin
            s_d.ms = s_q.saved;
        end else if (msr_wr) begin
            s_d.ms = msr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign srr0       = s_q.ret;
    assign srr1       = s_q.saved;
    assign msr        = s_q.ms;
    assign supervisor = !s_q.ms[MS_USER_BIT];
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
    parameter int AW = 32,
    parameter int MW = 8,
    parameter int NS = 4,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmp_valid,
    input logic [NS-1:0] cmp_fault,
    input logic          sq_empty,
    input logic          sreset_req,
    input logic          mcheck_req,
    input logic          rfi,
    input logic          flush,
    input logic          cmp_commit,
    input logic          redirect,
    input logic          take,
    input logic [CW-1:0] take_code,
    input logic [MW-1:0] srr1,
    input logic [MW-1:0] msr,
    input logic          supervisor
);
    // R1
    entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> supervisor && !msr[0]);
    // R1
    flush_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> redirect && take);
    // R2
    save_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> srr1 == $past(msr));
    // R3
    sreset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sreset_req |-> take && take_code == '0);
    // R8
    mcheck_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcheck_req && !sreset_req |-> take && take_code == CW'(1));
    // R5
    fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_fault != '0 |-> !cmp_commit);
    // R6
    async_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && int'(take_code) >= 2 + NS |-> sq_empty && cmp_commit && msr[0]);
    // R9
    rfi_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfi && !take |=> msr == $past(srr1));
endmodule

bind exc_seq_ctrl exc_seq_chk #(.AW(AW), .MW(MW), .NS(NS), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_valid  (cmp_valid),
    .cmp_fault  (cmp_fault),
    .sq_empty   (sq_empty),
    .sreset_req (sreset_req),
    .mcheck_req (mcheck_req),
    .rfi        (rfi),
    .flush      (flush),
    .cmp_commit (cmp_commit),
    .redirect   (redirect),
    .take       (take),
    .take_code  (take_code),
    .srr1       (srr1),
    .msr        (msr),
    .supervisor (supervisor)
);

// File: tb/sim_exc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_exc_seq_ctrl;
    localparam int AW = 32, MW = 8, NS = 4, NA = 2, CW = 3, ILEN = 4;
    localparam logic [NS-1:0] AFTER = 4'b1100;

    logic clk = 0, rst_n = 0;
    logic cmp_valid = 0, sq_empty = 0, sreset_req = 0, mcheck_req = 0, rfi = 0, msr_wr = 0;
    logic [AW-1:0] cmp_pc = '0;
    logic [NS-1:0] cmp_fault = '0;
    logic [NA-1:0] ext_req = '0, irq_en_mask = '0;
    logic [MW-1:0] msr_wdata = '0;
    logic flush, cmp_commit, redirect, take, supervisor;
    logic [AW-1:0] redirect_pc, srr0;
    logic [CW-1:0] take_code;
    logic [MW-1:0] srr1, msr;

    int checks = 0, failures = 0;
    logic [MW-1:0] m_msr = '0, m_srr1 = '0;
    logic [AW-1:0] m_srr0 = '0;
    logic [NA-1:0] m_pend = '0;

    always #5 clk = ~clk;

    exc_seq_ctrl u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] vec_of(input int code);
        return AW'((code + 1) << 8);
    endfunction

    // Reference model: evaluate the cycle from requirements, compare, advance.
    task automatic step();
        int code = -1, si = -1, ai = -1;
        logic [AW-1:0] ret = cmp_pc;
        bit e_take, e_commit;
        for (int i = NS - 1; i >= 0; i--) if (cmp_valid && cmp_fault[i]) si = i;
        for (int j = NA - 1; j >= 0; j--) if (m_pend[j] && irq_en_mask[j]) aj(j, ai);
        if (sreset_req) code = 0;
        else if (mcheck_req) code = 1;
        else if (si >= 0) begin
            code = 2 + si;
            if (AFTER[si]) ret = cmp_pc + ILEN;
        end else if (ai >= 0 && m_msr[0] && sq_empty && cmp_valid && !rfi) begin
            code = 2 + NS + ai;
            ret = cmp_pc + ILEN;
        end
        e_take = (code >= 0);
        e_commit = cmp_valid && !(code >= 0 && code < 2 + NS);
        #1;
        chk(take == e_take, "R3,R6,R7,R8", "take", 32'(take), 32'(e_take));
        if (e_take)
            chk(take_code == CW'(code), (code >= 2 && code < 2 + NS) ? "R4" : "R3",
                "code", 32'(take_code), 32'(code));
        chk(flush == e_take, "R1", "flush", 32'(flush), 32'(e_take));
        chk(redirect == (e_take || rfi), "R1,R9", "redirect", 32'(redirect), 32'(e_take || rfi));
        if (e_take)
            chk(redirect_pc == vec_of(code), "R1", "vector", redirect_pc, vec_of(code));
        else if (rfi)
            chk(redirect_pc == m_srr0, "R9", "return pc", redirect_pc, m_srr0);
        chk(cmp_commit == e_commit, "R5", "commit", 32'(cmp_commit), 32'(e_commit));
        chk(msr == m_msr, "R1,R9,R10", "msr", 32'(msr), 32'(m_msr));
        chk(srr0 == m_srr0, "R2", "srr0", srr0, m_srr0);
        chk(srr1 == m_srr1, "R2", "srr1", 32'(srr1), 32'(m_srr1));
        chk(supervisor == !m_msr[1], "R1", "supervisor", 32'(supervisor), 32'(!m_msr[1]));
        if (e_take) begin
            m_srr0 = ret;
            m_srr1 = m_msr;
            m_msr[1:0] = 2'b00;
            if (code >= 2 + NS) m_pend[code - 2 - NS] = 1'b0;
        end else if (rfi) m_msr = m_srr1;
        else if (msr_wr) m_msr = msr_wdata;
        m_pend = m_pend | ext_req;
    endtask

    task automatic aj(input int j, inout int ai);
        ai = j;
    endtask

    task automatic idle();
        cmp_valid = 1; cmp_fault = '0; ext_req = '0; sreset_req = 0;
        mcheck_req = 0; rfi = 0; msr_wr = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R11
        chk(msr == '0 && srr0 == '0 && srr1 == '0, "R11", "reset regs",
            32'(msr), 32'h0);
        chk(take == 1'b0, "R11", "no take after reset", 32'(take), 32'h0);

        // R10: enter user mode with interrupts enabled
        @(negedge clk); idle(); cmp_pc = 32'h100; msr_wr = 1; msr_wdata = 8'h03;
        irq_en_mask = 2'b11; sq_empty = 1; step();
        // R6: request while store queue busy is held
        @(negedge clk); idle(); cmp_pc = 32'h104; ext_req = 2'b10; sq_empty = 0; step();
        @(negedge clk); idle(); cmp_pc = 32'h108; step();
        @(negedge clk); idle(); cmp_pc = 32'h10c; sq_empty = 1; step();
        // R9: return, then R4 multiple faults pick lowest
        @(negedge clk); idle(); cmp_pc = 32'h700; rfi = 1; step();
        @(negedge clk); idle(); cmp_pc = 32'h110; cmp_fault = 4'b0110; step();
        // R5: trap class saves next address
        @(negedge clk); idle(); cmp_pc = 32'h200; rfi = 1; step();
        @(negedge clk); idle(); cmp_pc = 32'h110; cmp_fault = 4'b0100; step();
        // R7: masked request stays pending until unmasked
        @(negedge clk); idle(); cmp_pc = 32'h300; rfi = 1; irq_en_mask = 2'b00;
        ext_req = 2'b01; step();
        @(negedge clk); idle(); cmp_pc = 32'h304; step();
        @(negedge clk); idle(); cmp_pc = 32'h308; irq_en_mask = 2'b01; step();
        // R8: reset exception inside handler, with a fault present
        @(negedge clk); idle(); cmp_pc = 32'h400; cmp_fault = 4'b0001; sreset_req = 1;
        mcheck_req = 1; step();
        @(negedge clk); idle(); cmp_pc = 32'h404; mcheck_req = 1; step();

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            cmp_valid   = ($urandom % 8) != 0;
            cmp_pc      = $urandom & 32'hFFFF_FFFC;
            cmp_fault   = (($urandom % 6) == 0) ? NS'($urandom) : '0;
            ext_req     = (($urandom % 5) == 0) ? NA'($urandom) : '0;
            if (($urandom % 16) == 0) irq_en_mask = NA'($urandom);
            sq_empty    = ($urandom % 4) != 0;
            sreset_req  = ($urandom % 97) == 0;
            mcheck_req  = ($urandom % 53) == 0;
            rfi         = ($urandom % 11) == 0;
            msr_wr      = ($urandom % 9) == 0;
            msr_wdata   = MW'($urandom);
            step();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule